// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register core of an eight-pin I/O expander. It keeps an output-value register, a per-pin read-inversion mask and a per-pin direction register, and it samples the eight external pin levels through a two-flop synchroniser. A host reaches the four registers over a plain register bus with a 2-bit address, a write strobe, write data and a read strobe. The pin side gives the output value, the per-pin drive-high and drive-low enables, and a combined output enable for each pin. Serial-bus decoding sits outside the block.

Reads are streamed out. A read strobe sampled at a clock edge returns `bus_rdata` together with a one-cycle `bus_rvalid` pulse after that edge. There is no back-pressure: the block always accepts a read strobe, and the requester must capture the data in the cycle `bus_rvalid` is high. Back-to-back strobes give back-to-back results. A write and a read in the same cycle are both accepted, and the read returns the value held before the write.

Pin 0 is open-drain, so it can only pull low. Pins 1 to 7 are push-pull. After reset every pin is an input with its drivers off.

Top module: `gpx_port_bank`

## Requirements
- R1: After reset (the asynchronous active-low `rst_n`), reads of address 1 return 0x00, reads of address 2 return 0xF0 and reads of address 3 return 0xFF. All of `pin_drv_hi`, `pin_drv_lo` and `pin_oe` are 0.
- R2: A read of address 0 returns the synchronised pin sample XOR the inversion register, both taken at the edge that samples the read strobe. The value does not depend on the direction bits.
- R3: A write to address 0 changes no register and no pin output.
- R4: A read of address 1 returns the stored output value, not the level on the pins.
- R5: When bit n of address 2 is 1, bit n read from address 0 is inverted. When it is 0, the pin level is returned unchanged.
- R6: When bit n of address 3 is 1, pin n is an input. Its `pin_drv_hi[n]`, `pin_drv_lo[n]` and `pin_oe[n]` are 0 whatever output bit n holds.
- R7: Pin 0 is open-drain. `pin_drv_lo[0]` is 1 exactly when direction bit 0 is 0 and output bit 0 is 0. `pin_drv_hi[0]` is always 0.
- R8: For pins 1 to 7 with direction bit 0: `pin_drv_hi` equals the output bit and `pin_drv_lo` equals its inverse. `pin_oe[n]` is the OR of the two enables for every pin.
- R9: A write sampled at a clock edge updates the register, the drive enables and `pin_out` right after that same edge. `bus_rvalid` is high for exactly the one cycle after each edge that samples `bus_rd`, and low otherwise.
- R10: A pin level change made before edge k is returned by a read strobe sampled at edge k+2 or later. A read strobe sampled at edge k+1 still returns the old level.
- R11: Asserting `rst_n` low in the middle of operation returns every register and every drive enable to its R1 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pin levels, 1 output value, 2 inversion mask, 3 direction |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | One-cycle read result pulse |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output value register |
| pin_drv_hi | output | 8 | Per-pin drive-high enable |
| pin_drv_lo | output | 8 | Per-pin drive-low enable |
| pin_oe | output | 8 | Per-pin driver active |

## Verification
A corrupted direction or output bit shows up on the drive-enable outputs right after the clock edge that produced it, so the bench compares all three enable vectors after every write. A corrupted inversion bit, or a synchroniser of the wrong depth, shows up only at the next read of address 0. The bench therefore reads pin levels under several inversion masks, and it reads at both edge k+1 and edge k+2 after a pin change. A lost write to address 0 would be hidden, so the bench reads back the other three registers after that write.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned GPX_ADDR_W = 2;

  typedef enum logic [GPX_ADDR_W-1:0] {
    GPX_SEL_LEVEL = 2'd0,
    GPX_SEL_OUT   = 2'd1,
    GPX_SEL_INV   = 2'd2,
    GPX_SEL_DIR   = 2'd3
  } gpx_sel_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];

  // checker state: counts edges since reset, saturating
  logic [1:0] primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                primed_q <= '0;
    else if (primed_q != 2'd3) primed_q <= primed_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk2
    p_sync_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q == 2'd3) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] OUT_RST = '0,
  parameter logic [W-1:0] INV_RST = '0,
  parameter logic [W-1:0] DIR_RST = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [GPX_ADDR_W-1:0] addr,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          out_q,
  output logic [W-1:0]          inv_q,
  output logic [W-1:0]          dir_q
);
  gpx_sel_e sel;
  assign sel = gpx_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RST;
      inv_q <= INV_RST;
      dir_q <= DIR_RST;
    end else if (wr) begin
      unique case (sel)
        GPX_SEL_OUT: out_q <= wdata;
        GPX_SEL_INV: inv_q <= wdata;
        GPX_SEL_DIR: dir_q <= wdata;
        default:     ;
      endcase
    end
  end

  p_level_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == GPX_SEL_LEVEL) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

  p_out_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == GPX_SEL_OUT) |=> (out_q == $past(wdata)));
endmodule

// File: rtl/gpx_drive.sv
module gpx_drive #(
  parameter int unsigned  W       = 8,
  parameter logic [W-1:0] OD_MASK = 'h1
) (
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] drv_hi,
  output logic [W-1:0] drv_lo,
  output logic [W-1:0] oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic active;
    assign active    = ~dir_q[i];
    assign drv_lo[i] = active & ~out_q[i];
    if (OD_MASK[i]) begin : g_od
      assign drv_hi[i] = 1'b0;
    end else begin : g_pp
      assign drv_hi[i] = active & out_q[i];
    end
    assign oe[i] = drv_hi[i] | drv_lo[i];
  end

  always_comb begin
    a_no_contention_r8: assert ((drv_hi & drv_lo) == '0);
  end
endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
  import gpx_pkg::*;
#(
  parameter int unsigned  W           = 8,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [W-1:0] OD_MASK     = 'h01,
  parameter logic [W-1:0] OUT_RST     = 'h00,
  parameter logic [W-1:0] INV_RST     = 'hF0,
  parameter logic [W-1:0] DIR_RST     = 'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GPX_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [W-1:0]          bus_wdata,
  input  logic                  bus_rd,
  output logic [W-1:0]          bus_rdata,
  output logic                  bus_rvalid,
  input  logic [W-1:0]          pin_in,
  output logic [W-1:0]          pin_out,
  output logic [W-1:0]          pin_drv_hi,
  output logic [W-1:0]          pin_drv_lo,
  output logic [W-1:0]          pin_oe
);
  localparam logic [W-1:0] PP_MASK = ~OD_MASK;

  logic [W-1:0] level_s;
  logic [W-1:0] out_q, inv_q, dir_q;
  logic [W-1:0] rd_mux;

  gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(level_s)
  );

  gpx_regs #(.W(W), .OUT_RST(OUT_RST), .INV_RST(INV_RST), .DIR_RST(DIR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q)
  );

  gpx_drive #(.W(W), .OD_MASK(OD_MASK)) u_drive (
    .out_q(out_q), .dir_q(dir_q),
    .drv_hi(pin_drv_hi), .drv_lo(pin_drv_lo), .oe(pin_oe)
  );

  assign pin_out = out_q;

  always_comb begin
    unique case (gpx_sel_e'(bus_addr))
      GPX_SEL_LEVEL: rd_mux = level_s ^ inv_q;
      GPX_SEL_OUT:   rd_mux = out_q;
      GPX_SEL_INV:   rd_mux = inv_q;
      default:       rd_mux = dir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  p_rvalid_follows_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_dir_write_sets_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == GPX_SEL_DIR) |=> ((pin_oe & PP_MASK) == (~$past(bus_wdata) & PP_MASK)));

  p_inputs_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == GPX_SEL_DIR && bus_wdata == '1) |=> (pin_oe == '0));
endmodule

// File: tb/gpx_port_bank_tb.sv
module gpx_port_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_drv_hi, pin_drv_lo, pin_oe;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_out = 8'h00, m_inv = 8'hF0, m_dir = 8'hFF;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_port_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_drv_hi(pin_drv_hi), .pin_drv_lo(pin_drv_lo), .pin_oe(pin_oe)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R9 unexpected rvalid: actual 1 expected 0");
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic do_read(logic [1:0] a, logic [7:0] exp, string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd1: m_out = d;
      2'd2: m_inv = d;
      2'd3: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic check_drive(string tag);
    logic [7:0] hi, lo;
    hi = ~m_dir & m_out & 8'hFE;
    lo = ~m_dir & ~m_out;
    check({tag, " drv_hi"}, pin_drv_hi, hi);
    check({tag, " drv_lo"}, pin_drv_lo, lo);
    check({tag, " oe"}, pin_oe, hi | lo);
    check({tag, " pin_out"}, pin_out, m_out);
  endtask

  task automatic set_pins(logic [7:0] v);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_all(string tag);
    do_read(2'd1, m_out, {tag, " out reg"});
    do_read(2'd2, m_inv, {tag, " inv reg"});
    do_read(2'd3, m_dir, {tag, " dir reg"});
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset defaults
    check_drive("R1 reset");
    check("R9 rvalid idle", {7'd0, bus_rvalid}, 8'h00);
    read_all("R1");

    // R2/R5 input levels through default inversion 0xF0
    set_pins(8'hA5);
    do_read(2'd0, 8'hA5 ^ 8'hF0, "R2 level default inv");
    do_write(2'd2, 8'h00);
    do_read(2'd0, 8'hA5, "R5 inv clear passes");
    do_write(2'd2, 8'h0F);
    do_read(2'd0, 8'hAA, "R5 low nibble inverted");

    // R4 output register read returns stored value
    do_write(2'd1, 8'h3C);
    do_read(2'd1, 8'h3C, "R4 out readback");
    // R6 still all inputs: no drive despite output bits
    check_drive("R6 inputs ignore out");

    // R8/R7 all outputs
    do_write(2'd3, 8'h00);
    check_drive("R8 all outputs 3C");
    check("R7 pin0 pulls low", {7'd0, pin_drv_lo[0]}, 8'h01);
    do_write(2'd1, 8'h01);
    check_drive("R9 out write timing");
    check("R7 pin0 released", {7'd0, pin_drv_hi[0] | pin_drv_lo[0]}, 8'h00);
    do_write(2'd1, 8'hFF);
    check("R7 pin0 never high", {7'd0, pin_drv_hi[0]}, 8'h00);
    check_drive("R8 all high");

    // R2 level read independent of direction; R4 not pin level
    set_pins(8'h5A);
    do_read(2'd0, 8'h5A ^ 8'h0F, "R2 level with outputs");
    do_read(2'd1, 8'hFF, "R4 out not pin");

    // R6 mixed directions
    do_write(2'd3, 8'hF0);
    do_write(2'd1, 8'h96);
    check_drive("R6 mixed dir");

    // R3 write to level register ignored
    do_write(2'd0, 8'h77);
    check_drive("R3 drive unchanged");
    read_all("R3");

    // R10 synchroniser latency
    do_write(2'd2, 8'h00);
    set_pins(8'h00);
    pin_in = 8'hC3;
    @(negedge clk);
    do_read(2'd0, 8'h00, "R10 old at edge k+1");
    do_read(2'd0, 8'hC3, "R10 new at edge k+2");
    @(negedge clk);

    // R11 reset in mid operation
    rst_n = 1'b0;
    @(negedge clk);
    m_out = 8'h00; m_inv = 8'hF0; m_dir = 8'hFF;
    check_drive("R11 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_drive("R11 after reset");
    read_all("R11");

    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", 8'(exp_q.size()), 8'd0);
    finish_run();
  end
endmodule